// File: doc/BRIEF.md
# Timer count clock selector

This block produces the one-cycle count-enable pulse that advances an 8-bit timer/event counter. A 3-bit selector, held in a byte-wide control register, picks where that pulse comes from. It can come from the falling or the rising edge of an external event pin. It can also come from one tap of a free-running 13-bit prescaler that divides the peripheral clock by 1, 2, 4, 64, 256 or 8192.

The counter it feeds returns a run/stop level. While `run` is low the enable is held off and the prescaler is kept at zero, so a divided source always starts counting from a known phase.

The control register is written either as a whole byte or one bit at a time. Software may change the selector only while the timer is stopped. A write that arrives while running is discarded and latches a sticky error flag.

Top module: `tmr_clksel`

## Requirements
- R1: After reset the register reads 0x00, which selects falling-edge counting, and `wr_err` is 0.
- R2: With selector 000 and `run` high, each falling edge of `evt_pin` gives exactly one `cnt_en` pulse. The pulse is high in the clock cycle that follows the second rising clock edge after the pin change.
- R3: With selector 001 and `run` high, each rising edge of `evt_pin` gives exactly one `cnt_en` pulse, with the same latency as R2.
- R4: Selectors 010, 011, 100, 101, 110 and 111 divide by 1, 2, 4, 64, 256 and 8192 respectively. Cycles are numbered from 1, starting with the first cycle in which `run` is high. `cnt_en` is high in cycle k exactly when k is a multiple of the ratio.
- R5: While `run` is low, `cnt_en` is 0 for every selector, and the prescaler restarts from zero.
- R6: A byte write (`wr_en`) while stopped stores `wr_data[2:0]` as the selector. Bits 7:3 of the write are discarded.
- R7: A bit write (`wr_bit`) while stopped sets register bit `wr_bit_idx` to `wr_data[0]`. Indices 3 to 7 change nothing. If `wr_en` and `wr_bit` are both high, the byte write wins.
- R8: Any write while `run` is high leaves the register unchanged and sets `wr_err`. `wr_err` stays at 1 until reset.
- R9: `rd_data` always returns the selector in bits 2:0 and zero in bits 7:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Timer running level from the counter |
| evt_pin | input | 1 | Asynchronous external event pin |
| wr_en | input | 1 | Byte write strobe |
| wr_bit | input | 1 | Single-bit write strobe |
| wr_bit_idx | input | 3 | Bit index for a single-bit write |
| wr_data | input | 8 | Write data; bit 0 carries a single-bit write |
| rd_data | output | 8 | Register read value |
| cnt_en | output | 1 | One-cycle count-enable to the counter |
| wr_err | output | 1 | Sticky flag for a write while running |

## Verification
Register writes, `rd_data` and `wr_err` take effect one edge after the write cycle. A divided enable is due in the N-th running cycle and every N-th one after it. An external edge is due in the cycle after the second clock edge that follows the pin change.

The bench keeps a behavioural model that counts running cycles and holds a three-deep history of pin samples. It drives inputs just after each rising edge and compares all three outputs against the model at every falling edge, so each result is checked in the cycle it is due.

// File: rtl/tmr_clksel.sv
module tmr_clksel #(
  parameter int PRE_W = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       evt_pin,
  input  logic       wr_en,
  input  logic       wr_bit,
  input  logic [2:0] wr_bit_idx,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       cnt_en,
  output logic       wr_err
);
  logic [2:0]       sel_q;
  logic [PRE_W-1:0] pre_q;
  logic [2:0]       pin_q;
  logic             wr_any, rise, fall;
  logic [7:0]       src;

  assign wr_any = wr_en | wr_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      wr_err <= 1'b0;
    end else if (wr_any) begin
      if (run) wr_err <= 1'b1;
      else if (wr_en) sel_q <= wr_data[2:0];
      else if (wr_bit_idx < 3'd3) sel_q[wr_bit_idx[1:0]] <= wr_data[0];
    end
  end

  assign rd_data = {5'b0, sel_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (!run) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else pin_q <= {pin_q[1:0], evt_pin};
  end

  assign rise = pin_q[1] & ~pin_q[2];
  assign fall = ~pin_q[1] & pin_q[2];

  assign src[0] = fall;
  assign src[1] = rise;
  assign src[2] = 1'b1;
  assign src[3] = pre_q[0];
  assign src[4] = &pre_q[1:0];
  assign src[5] = &pre_q[5:0];
  assign src[6] = &pre_q[7:0];
  assign src[7] = &pre_q[PRE_W-1:0];

  assign cnt_en = run & src[sel_q];

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n) !run |-> !cnt_en);
  p_locked_r8: assert property (@(posedge clk) disable iff (!rst_n) (run && wr_any) |=> $stable(sel_q));
  p_errset_r8: assert property (@(posedge clk) disable iff (!rst_n) (run && wr_any) |=> wr_err);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n) wr_err |=> wr_err);
  p_single_r2: assert property (@(posedge clk) disable iff (!rst_n) (cnt_en && sel_q < 3'd2) |=> !cnt_en);
  p_half_r4: assert property (@(posedge clk) disable iff (!rst_n) (cnt_en && sel_q == 3'd3) |=> !cnt_en);
endmodule

// File: tb/tmr_clksel_tb_top.sv
module tmr_clksel_tb_top;
  logic clk = 0, rst_n = 0, run = 0, evt_pin = 0, wr_en = 0, wr_bit = 0;
  logic [2:0] wr_bit_idx = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic cnt_en, wr_err;
  int n_chk = 0, n_fail = 0, cyc = 0;

  bit q[$] = '{0, 0, 0};
  int run_cnt = 0;
  logic [7:0] reg_m = 0;
  bit err_m = 0;

  always #10 clk = ~clk;

  tmr_clksel dut_i (.clk(clk), .rst_n(rst_n), .run(run), .evt_pin(evt_pin),
    .wr_en(wr_en), .wr_bit(wr_bit), .wr_bit_idx(wr_bit_idx), .wr_data(wr_data),
    .rd_data(rd_data), .cnt_en(cnt_en), .wr_err(wr_err));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int ratio(logic [2:0] s);
    case (s)
      3'd2: return 1;
      3'd3: return 2;
      3'd4: return 4;
      3'd5: return 64;
      3'd6: return 256;
      default: return 8192;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
    if (rst_n) begin
      q.push_back(evt_pin);
      void'(q.pop_front());
      run_cnt = run ? run_cnt + 1 : 0;
      if (wr_en || wr_bit) begin
        if (run) err_m = 1;
        else if (wr_en) reg_m = {5'b0, wr_data[2:0]};
        else if (wr_bit_idx < 3) reg_m[wr_bit_idx] = wr_data[0];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_en;
      string tag;
      if (!run) begin exp_en = 0; tag = "R5"; end
      else if (reg_m == 0) begin exp_en = q[1] == 0 && q[0] == 1; tag = "R2"; end
      else if (reg_m == 1) begin exp_en = q[1] == 1 && q[0] == 0; tag = "R3"; end
      else begin exp_en = ((run_cnt + 1) % ratio(reg_m[2:0])) == 0; tag = "R4"; end
      chk(tag, cnt_en, exp_en);
      chk("R9", rd_data, reg_m);
      chk("R8", wr_err, err_m);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_byte(logic [7:0] d);
    wr_en = 1; wr_data = d; tick(); wr_en = 0; wr_data = 0;
  endtask

  task automatic wr_one(int idx, bit b);
    wr_bit = 1; wr_bit_idx = 3'(idx); wr_data = {7'b0, b}; tick(); wr_bit = 0; wr_data = 0;
  endtask

  task automatic pins(int n);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(0, 3) == 0) evt_pin = ~evt_pin;
      tick();
    end
  endtask

  task automatic run_mode(logic [7:0] code, int n);
    wr_byte(code);
    run = 1; pins(n); run = 0; tick(2);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    chk("R1", rd_data, 0);
    chk("R1", wr_err, 0);
    run = 1; pins(400); run = 0; tick(2);
    run_mode(8'h01, 400);
    wr_byte(8'hFB);
    chk("R6", rd_data, 8'h03);
    run = 1; pins(100); run = 0; tick(2);
    run_mode(8'h02, 50);
    run_mode(8'h04, 60);
    run_mode(8'h05, 300);
    run_mode(8'h06, 800);
    wr_one(2, 0);
    chk("R7", rd_data, 8'h02);
    wr_one(6, 1);
    chk("R7", rd_data, 8'h02);
    wr_one(0, 1);
    chk("R7", rd_data, 8'h03);
    wr_en = 1; wr_bit = 1; wr_bit_idx = 0; wr_data = 8'h04; tick();
    wr_en = 0; wr_bit = 0; wr_data = 0;
    chk("R7", rd_data, 8'h04);
    run = 1; pins(40);
    chk("R8", wr_err, 0);
    wr_byte(8'h07);
    chk("R8", rd_data, 8'h04);
    chk("R8", wr_err, 1);
    pins(30); run = 0; tick(3);
    run_mode(8'h07, 17000);
    run = 1; tick(5); run = 0; tick(1); run = 1; tick(20); run = 0;
    chk("R8", wr_err, 1);
    wr_byte(8'h07);
    run = 1; pins(9000); run = 0; tick(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule